// File: doc/BRIEF.md
# Nibble Palette Pixel Mapper

This block takes 32-bit frame words from a display FIFO and splits each one into pixels of 1, 2 or 4 bits. Each pixel value is an index into a table of sixteen 4-bit grey levels. The table is held in two 32-bit palette registers. For every pixel the block presents the grey level that the table holds at that index. The output is a valid/ready stream, one grey level per transfer.

The word input is also valid/ready. A word is accepted only when no word is held, or when the last pixel of the held word leaves on that same edge. This lets consecutive words stream with no gap. When the pixel sink holds `pix_ready` low, the block keeps the current pixel and stops taking words. When the FIFO has no word, the pixel stream pauses with `pix_valid` low.

The palette registers can be written at any time through a plain write port. A write changes the grey level of the pixel being presented from the next cycle on. At reset the palette holds direct mapping, so every entry equals its own index. Writing the complemented table turns the image into reverse video without touching the frame data.

Top module: `nib_pixmap_top`

## Requirements
- R1: After reset `pix_valid` is low, `word_ready` is high, and every palette entry n holds the value n.
- R2: `depth_sel` encodes bits per pixel as 2'b00 = 1 bpp, 2'b01 = 2 bpp, 2'b10 = 4 bpp. A word yields 32, 16 or 8 pixels respectively. Pixel k occupies word bits [k*b+b-1 : k*b], so pixels are taken from the least significant bits upward.
- R3: The table index is the pixel value zero-extended to 4 bits. At 1 bpp only entries 0 and 1 are reached, and at 2 bpp only entries 0 to 3.
- R4: `pix_grey` equals table entry idx. Entries 0..7 sit in palette register 0 and entries 8..15 in register 1. Entry n of a register is at bits [4m+3:4m], where m = n mod 8.
- R5: A write with `pal_wr_en` high loads `pal_wr_data` into register `pal_wr_sel` on the clock edge. The pixel presented in the following cycle uses the new value, even if that pixel was already waiting.
- R6: While `pix_valid` is high and `pix_ready` is low, the next cycle keeps `pix_valid` high and shows the same pixel.
- R7: `word_ready` is high exactly when no word is held, or when the held word's last pixel is transferred in that cycle. Back-to-back words therefore produce pixels with no idle cycle between them.
- R8: Once the held word's last pixel is transferred and no new word is accepted, `pix_valid` is low in the next cycle.
- R9: Depth is captured when a word is accepted. A change of `depth_sel` while that word drains has no effect on its pixels.
- R10: Depth code 2'b11 behaves as 4 bpp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_sel | input | 2 | Bits-per-pixel code, sampled on word acceptance |
| word_valid | input | 1 | Frame word available from the FIFO |
| word_ready | output | 1 | Block takes the frame word on this edge |
| word_data | input | 32 | Frame word |
| pix_valid | output | 1 | Grey level on `pix_grey` is valid |
| pix_ready | input | 1 | Sink accepts the pixel |
| pix_grey | output | 4 | Grey level of the current pixel |
| pal_wr_en | input | 1 | Palette register write strobe |
| pal_wr_sel | input | 1 | Palette register select: 0 = entries 0..7, 1 = entries 8..15 |
| pal_wr_data | input | 32 | Palette register write value |

## Verification
Words with a distinct value in every nibble are fed at 4 bpp with direct, inverted and scrambled palettes. These cases separate index extraction from table lookup and show whether the two registers are swapped. Alternating and walking bit patterns at 2 and 1 bpp reveal wrong pixel order, a wrong shift step, wrong pixel counts and missing index masking. Stalled sinks, back-to-back words, mid-word palette writes, a depth change in the middle of a word and code 2'b11 exercise the handshake and capture rules.

// File: rtl/pixmap_pkg.sv
package pixmap_pkg;
  typedef enum logic [1:0] {
    DEP_1 = 2'b00,
    DEP_2 = 2'b01,
    DEP_4 = 2'b10,
    DEP_4B = 2'b11
  } depth_e;

  // log2 of bits per pixel for a depth code; the spare code maps to 4 bpp
  function automatic logic [1:0] depth_lg(input depth_e d);
    case (d)
      DEP_1:   depth_lg = 2'd0;
      DEP_2:   depth_lg = 2'd1;
      default: depth_lg = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/pm_palette.sv
module pm_palette #(
  parameter int REG_W   = 32,
  parameter int GREY_W  = 4,
  parameter int ENTRIES = 16,
  localparam int EPR    = REG_W / GREY_W,
  localparam int NREG   = ENTRIES / EPR,
  localparam int SEL_W  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]  idx,
  output logic [GREY_W-1:0] grey
);
  logic [REG_W-1:0]  bank [NREG];
  logic [GREY_W-1:0] tbl  [ENTRIES];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int e = 0; e < EPR; e++)
          bank[r][e*GREY_W +: GREY_W] <= GREY_W'(r * EPR + e);
      end else if (wr_en && (wr_sel == SEL_W'(r))) begin
        bank[r] <= wr_data;
      end
    end

    for (genvar e = 0; e < EPR; e++) begin : g_ent
      assign tbl[r*EPR + e] = bank[r][e*GREY_W +: GREY_W];
    end

    AST_PAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && (wr_sel == SEL_W'(r)) && rst_n) |-> bank[r] == $past(wr_data)); // R5
    AST_PAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!(wr_en && (wr_sel == SEL_W'(r))) && rst_n) |-> $stable(bank[r])); // R5
  end

  assign grey = tbl[idx];
endmodule

// File: rtl/pm_unpack.sv
module pm_unpack
  import pixmap_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 4,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  depth_e            depth_i,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [IDX_W-1:0]  pix_idx
);
  logic [WORD_W-1:0] cur_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              have_q;
  depth_e            dep_q;

  logic [1:0]        lg;
  logic [CNT_W-1:0]  off;
  logic [WORD_W-1:0] shifted;
  logic [IDX_W-1:0]  mask;
  logic              last, take_pix, take_word;

  always_comb begin
    lg       = depth_lg(dep_q);
    off      = CNT_W'(cnt_q << lg);
    shifted  = cur_q >> off;
    mask     = IDX_W'((1 << (1 << lg)) - 1);
    pix_idx  = shifted[IDX_W-1:0] & mask;
    last     = (cnt_q == CNT_W'((WORD_W >> lg) - 1));
    take_pix = have_q && pix_ready;
  end

  assign pix_valid  = have_q;
  assign word_ready = !have_q || (last && pix_ready);
  assign take_word  = word_valid && word_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      cnt_q  <= '0;
      have_q <= 1'b0;
      dep_q  <= DEP_4;
    end else if (take_word) begin
      cur_q  <= word_data;
      cnt_q  <= '0;
      have_q <= 1'b1;
      dep_q  <= depth_i;
    end else if (take_pix) begin
      if (last) have_q <= 1'b0;
      else      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_HOLD_PIX: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_idx)); // R6
  AST_IDX_1BPP: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && dep_q == DEP_1 |-> pix_idx < IDX_W'(2)); // R3
  AST_IDX_2BPP: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && dep_q == DEP_2 |-> pix_idx < IDX_W'(4)); // R3
  AST_DEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_word |=> $stable(dep_q)); // R9
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    take_pix && last && !word_valid |=> !pix_valid); // R8
endmodule

// File: rtl/nib_pixmap_top.sv
module nib_pixmap_top
  import pixmap_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int GREY_W  = 4,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int NREG   = ENTRIES * GREY_W / WORD_W,
  localparam int SEL_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        depth_sel,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [GREY_W-1:0] pix_grey,
  input  logic              pal_wr_en,
  input  logic [SEL_W-1:0]  pal_wr_sel,
  input  logic [WORD_W-1:0] pal_wr_data
);
  logic [IDX_W-1:0] idx;

  pm_unpack #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .depth_i    (depth_e'(depth_sel)),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .word_data  (word_data),
    .pix_valid  (pix_valid),
    .pix_ready  (pix_ready),
    .pix_idx    (idx)
  );

  pm_palette #(.REG_W(WORD_W), .GREY_W(GREY_W), .ENTRIES(ENTRIES)) u_pal (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pal_wr_en),
    .wr_sel  (pal_wr_sel),
    .wr_data (pal_wr_data),
    .idx     (idx),
    .grey    (pix_grey)
  );

  AST_STALL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |-> !word_ready); // R7
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> word_ready); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(!rst_n) |-> !pix_valid); // R1
endmodule

// File: tb/nib_pixmap_top_tb.sv
module nib_pixmap_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  depth_sel = 2'b10;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [31:0] word_data = '0;
  logic        pix_valid;
  logic        pix_ready = 1'b0;
  logic [3:0]  pix_grey;
  logic        pal_wr_en = 1'b0;
  logic        pal_wr_sel = 1'b0;
  logic [31:0] pal_wr_data = '0;

  int total = 0;
  int bad = 0;
  logic [3:0] pal [16];

  always #2 clk = ~clk;

  nib_pixmap_top u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pal_write(input bit sel, input [31:0] val);
    @(negedge clk);
    pal_wr_en = 1'b1; pal_wr_sel = sel; pal_wr_data = val;
    @(posedge clk); #1;
    pal_wr_en = 1'b0;
    for (int e = 0; e < 8; e++) pal[sel*8 + e] = val[e*4 +: 4];
  endtask

  function automatic int bpp_of(input [1:0] c);
    return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 4;
  endfunction

  // load one word into an empty block, drain it; optional stall and mid-word depth change
  task automatic run_word(input [31:0] w, input [1:0] dep, input bit stall,
                          input bit chg, input [1:0] dep_mid, input string req);
    int b, n, idx, badpix;
    logic [3:0] held;
    b = bpp_of(dep); n = 32 / b; badpix = 0;
    @(negedge clk);
    check(word_ready === 1'b1 && pix_valid === 1'b0, "R7 idle ready", word_ready, 1);
    depth_sel = dep; word_valid = 1'b1; word_data = w; pix_ready = 1'b0;
    @(posedge clk); #1;
    word_valid = 1'b0;
    if (chg) depth_sel = dep_mid;
    for (int k = 0; k < n; k++) begin
      idx = (w >> (k * b)) & ((1 << b) - 1);
      @(negedge clk);
      if (stall && k == 1) begin
        held = pix_grey;
        @(negedge clk);
        check(pix_valid === 1'b1 && pix_grey === held, "R6 stalled pixel held", pix_grey, held);
      end
      if (!(pix_valid === 1'b1 && pix_grey === pal[idx])) begin
        badpix++;
        if (badpix == 1) check(0, req, pix_grey, pal[idx]);
      end
      pix_ready = 1'b1;
      @(posedge clk); #1;
      pix_ready = 1'b0;
    end
    if (badpix == 0) check(1, req, 0, 0);
    @(negedge clk);
    check(pix_valid === 1'b0, "R8 valid drops after last pixel", pix_valid, 0);
    depth_sel = 2'b10;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(pix_valid === 1'b0, "R1 valid low after reset", pix_valid, 0);
    check(word_ready === 1'b1, "R1 word_ready after reset", word_ready, 1);
    run_word(32'hFEDC_BA98, 2'b10, 0, 0, 2'b00, "R1 identity palette high entries");
    run_word(32'h7654_3210, 2'b10, 0, 0, 2'b00, "R4 identity palette low entries");
  endtask

  task automatic t_depths;
    run_word(32'hE4E4_1B72, 2'b01, 0, 0, 2'b00, "R2 2bpp order and count");
    run_word(32'h8000_A5C1, 2'b00, 0, 0, 2'b00, "R2 1bpp order and count");
    run_word(32'h3C5A_9F0E, 2'b11, 0, 0, 2'b00, "R10 code 11 acts as 4bpp");
  endtask

  task automatic t_palette;
    pal_write(1'b0, 32'h8967_45F3);
    pal_write(1'b1, 32'h2A1B_0CED);
    run_word(32'hFEDC_BA98, 2'b10, 0, 0, 2'b00, "R4 scrambled high register");
    run_word(32'h0123_4567, 2'b10, 0, 0, 2'b00, "R4 scrambled low register");
    run_word(32'hFFFF_0000, 2'b01, 0, 0, 2'b00, "R3 2bpp uses entries 0..3");
    run_word(32'hFFFF_FFFF, 2'b00, 0, 0, 2'b00, "R3 1bpp uses entries 0..1");
    pal_write(1'b0, 32'h89AB_CDEF);
    pal_write(1'b1, 32'h0123_4567);
    run_word(32'h1F2E_3D4C, 2'b10, 1, 0, 2'b00, "R5 reverse video palette");
  endtask

  task automatic t_midword_write;
    @(negedge clk);
    depth_sel = 2'b10; word_valid = 1'b1; word_data = 32'h0000_0005;
    @(posedge clk); #1;
    word_valid = 1'b0;
    @(negedge clk);
    check(pix_grey === pal[5], "R4 before write", pix_grey, pal[5]);
    pal_write(1'b0, 32'h0090_0000);
    @(negedge clk);
    check(pix_valid === 1'b1 && pix_grey === 4'h9, "R5 write seen by waiting pixel", pix_grey, 9);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); pix_ready = 1'b1;
      @(posedge clk); #1; pix_ready = 1'b0;
    end
    @(negedge clk);
    check(pix_valid === 1'b0, "R8 empty after drain", pix_valid, 0);
  endtask

  task automatic t_stall_and_depth;
    run_word(32'hA5A5_A5A5, 2'b01, 1, 1, 2'b00, "R9 depth change mid-word ignored");
    run_word(32'h0000_00F0, 2'b10, 1, 1, 2'b01, "R9 4bpp word kept after depth change");
  endtask

  task automatic t_back_to_back;
    int gaps;
    gaps = 0;
    @(negedge clk);
    depth_sel = 2'b10; word_valid = 1'b1; word_data = 32'h7654_3210;
    @(posedge clk); #1;
    word_data = 32'hFEDC_BA98;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      pix_ready = 1'b1;
      #0;
      if (k == 7) check(word_ready === 1'b1, "R7 ready on last pixel", word_ready, 1);
      if (k == 3) begin
        pix_ready = 1'b0; #0;
        check(word_ready === 1'b0, "R7 not ready mid-word", word_ready, 0);
        pix_ready = 1'b1;
      end
      if (pix_valid !== 1'b1 || pix_grey !== pal[(k < 8) ? k : k]) gaps++;
      @(posedge clk); #1;
      if (k == 7) word_valid = 1'b0;
    end
    pix_ready = 1'b0;
    check(gaps == 0, "R7 no gap between words", gaps, 0);
    @(negedge clk);
    check(pix_valid === 1'b0, "R8 empty after two words", pix_valid, 0);
  endtask

  initial begin
    for (int e = 0; e < 16; e++) pal[e] = 4'(e);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_depths();
    t_palette();
    t_midword_write();
    for (int e = 0; e < 8; e++) pal[e] = 4'(e);
    for (int e = 8; e < 16; e++) pal[e] = 4'(e);
    pal_write(1'b0, 32'h7654_3210);
    pal_write(1'b1, 32'hFEDC_BA98);
    t_stall_and_depth();
    t_back_to_back();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule